// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the slave side of a two-wire serial bus, the clock line plus one open-drain data line. It sits in front of a 512-byte memory. It brings both bus lines into the system clock domain and finds clock edges and bus conditions in the synchronized samples. After a start condition it takes in an address byte. It checks the fixed device-type nibble and two strap inputs, then acknowledges. It then reads out memory or passes received bytes to a separate write-cycle controller.

The address byte carries one bit of the memory address rather than a third device-select bit. Two straps therefore pick one of four devices on a shared bus, and the 9-bit memory address is split across two bytes. Writes are passed on one byte per cycle-wide pulse. Reads fetch each byte from a combinational memory read port. A start condition in the middle of a transfer restarts address reception, so a dummy write followed by a repeated start gives a random read.

Top module: `twm_slave`

## Requirements
- R1: Until a start condition is seen (data line falling while the clock line is high), bytes clocked on the bus get no acknowledge.
- R2: The address byte is sent MSB first and holds, from bit 7 down: the device type 1010 in bits 7..4, the strap match in bits 3..2 (bit 3 against strap_i[1], bit 2 against strap_i[0]), memory address bit 8 in bit 1, and the direction in bit 0 (1 = read, 0 = write). A matching byte is acknowledged by pulling the data line low for the ninth clock. A byte that does not match gets no acknowledge, and the block stays silent until the next start.
- R3: In write direction, the word-address byte and every data byte are acknowledged. Each data byte produces exactly one single-cycle wr_valid_o pulse carrying the byte and its 9-bit address, whose bit 8 comes from the address byte and bits 7..0 from the word-address byte.
- R4: The address advances by one after each data byte, written or read, and wraps from 511 to 0.
- R5: A repeated start after the word address, followed by a matching read address byte, returns the memory byte at the stored address, with bit 8 taken from the read address byte. Data bits are sent MSB first.
- R6: In read direction, a master acknowledge on the ninth clock makes the block send the byte at the next address.
- R7: A master no-acknowledge on the ninth clock of a read ends driving. The block pulls the data line low on no further clocks until a stop or start.
- R8: A stop condition (data line rising while the clock line is high) returns the block to idle with the data line released, and the next start is served normally.
- R9: A start condition in the middle of any byte abandons that byte, with no write pulse for a partial data byte, and restarts address-byte reception.
- R10: The block changes its data-line pull only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 = pull the data line low; 0 = release it |
| strap_i | input | 2 | Device select straps compared with address-byte bits 3..2 |
| rd_addr_o | output | 9 | Memory read address |
| rd_data_i | input | 8 | Memory read data, combinational from rd_addr_o |
| wr_valid_o | output | 1 | One-cycle pulse: a received data byte is ready |
| wr_addr_o | output | 9 | Address of the handed-off byte |
| wr_data_o | output | 8 | Handed-off data byte |

## Verification
A wrong bit counter or phase state shows on the ninth clock of the affected byte: the acknowledge is missing or out of place, or read data comes out shifted. A master sees this within one byte time. A wrong address counter is invisible until data moves. It then shows as the wrong read byte or the wrong wr_addr_o on the next transfer, including the wrap from 511 to 0. A missed stop or start leaves the block pulling or deaf on later bytes. Any pull change while the clock line is high would be taken by other devices as a bus condition.

// File: rtl/twm_pkg.sv
// Shared types for the two-wire memory slave.
package twm_pkg;

    // Protocol phase of the slave controller.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,  // waiting for a start condition
        ST_DEVADR = 3'd1,  // receiving the address byte
        ST_ACKA   = 3'd2,  // acknowledging the address byte
        ST_WADR   = 3'd3,  // receiving the word address
        ST_ACKW   = 3'd4,  // acknowledging a word address or data byte
        ST_WDATA  = 3'd5,  // receiving a write data byte
        ST_RDATA  = 3'd6,  // sending a read data byte
        ST_RACK   = 3'd7   // sampling master acknowledge; reused as hold
    } state_t;

endpackage

// File: rtl/twm_line_sync.sv
// Synchronizes the bus clock and data lines into the system clock domain
// and derives clock edges and start/stop events from the synchronized
// samples. Assumes the bus is idle-high and the system clock is at least
// several times faster than the bus clock.
module twm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [1:0] raw;
    logic [1:0] synced;
    logic       scl_q, sda_q;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] chain;
        // Metastability chain for one bus line, reset to the idle-high level.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    assign scl_s = synced[1];
    assign sda_s = synced[0];

    // Previous synchronized sample of both lines for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twm_addr_ctr.sv
// Memory address register: the high bit and the low bits load separately
// from the two address bytes, and the whole register increments with
// natural wrap. Assumes no load and increment in the same cycle.
module twm_addr_ctr #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi,
    input  logic              hi_bit,
    input  logic              ld_lo,
    input  logic [ADDR_W-2:0] lo_bits,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);
    // Load or advance the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (inc) begin
            addr <= addr + 1'b1;
        end else begin
            if (ld_hi) addr[ADDR_W-1]   <= hi_bit;
            if (ld_lo) addr[ADDR_W-2:0] <= lo_bits;
        end
    end

endmodule

// File: rtl/twm_slave.sv
// Two-wire bus slave for a 512-byte memory. Receives the address byte,
// matches the device type and straps, handles word address, write data
// handoff and sequential reads with master acknowledge. Assumes a
// combinational memory read port and a bus clock far slower than clk.
module twm_slave #(
    parameter int         DATA_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_TYPE    = 4'b1010,
    localparam int        ADDR_W      = DATA_W + 1,
    localparam int        CNT_W       = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [1:0]        strap_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);
    import twm_pkg::*;

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    state_t            st;
    logic [CNT_W-1:0]  bcnt;
    logic              bdone;
    logic [DATA_W-1:0] sh, tx;
    logic              rw, mack, pull, hold;
    logic              ld_hi, ld_lo, inc, match;
    logic [ADDR_W-1:0] addr;

    twm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
    );

    // Address byte compare against device type and straps.
    assign match = (sh[DATA_W-1:DATA_W-4] == DEV_TYPE) && (sh[3:2] == strap_i);

    // Address counter controls, all at the clock fall closing a byte.
    always_comb begin
        ld_hi = scl_fall && bdone && !start_ev && !stop_ev && (st == ST_DEVADR) && match;
        ld_lo = scl_fall && bdone && !start_ev && !stop_ev && (st == ST_WADR);
        inc   = scl_fall && bdone && !start_ev && !stop_ev &&
                ((st == ST_WDATA) || (st == ST_RDATA));
    end

    twm_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .ld_hi(ld_hi), .hi_bit(sh[1]),
        .ld_lo(ld_lo), .lo_bits(sh), .inc(inc), .addr(addr)
    );

    assign rd_addr_o  = addr;
    assign sda_pull_o = pull;

    // Protocol sequencer: bit reception, acknowledge and read data drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; bcnt <= '0; bdone <= 1'b0; sh <= '0; tx <= '0;
            rw <= 1'b0; mack <= 1'b0; pull <= 1'b0; hold <= 1'b0;
            wr_valid_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
        end else begin
            wr_valid_o <= 1'b0;
            if (start_ev) begin
                st <= ST_DEVADR; bcnt <= '0; bdone <= 1'b0; pull <= 1'b0; hold <= 1'b0;
            end else if (stop_ev) begin
                st <= ST_IDLE; bdone <= 1'b0; pull <= 1'b0; hold <= 1'b0;
            end else if (scl_rise) begin
                case (st)
                    ST_DEVADR, ST_WADR, ST_WDATA: begin
                        sh    <= {sh[DATA_W-2:0], sda_s};
                        bcnt  <= bcnt + 1'b1;
                        bdone <= (bcnt == CNT_W'(DATA_W - 1));
                    end
                    ST_RDATA: begin
                        bcnt  <= bcnt + 1'b1;
                        bdone <= (bcnt == CNT_W'(DATA_W - 1));
                    end
                    ST_RACK:  mack <= !sda_s && !hold;
                    default: ;
                endcase
            end else if (scl_fall) begin
                case (st)
                    ST_DEVADR: if (bdone) begin
                        bdone <= 1'b0;
                        if (match) begin
                            rw <= sh[0]; pull <= 1'b1; st <= ST_ACKA;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                    ST_WADR: if (bdone) begin
                        bdone <= 1'b0; pull <= 1'b1; st <= ST_ACKW;
                    end
                    ST_WDATA: if (bdone) begin
                        bdone <= 1'b0; pull <= 1'b1; st <= ST_ACKW;
                        wr_valid_o <= 1'b1; wr_addr_o <= addr; wr_data_o <= sh;
                    end
                    ST_ACKA: begin
                        bcnt <= '0;
                        if (rw) begin
                            tx <= rd_data_i; pull <= !rd_data_i[DATA_W-1]; st <= ST_RDATA;
                        end else begin
                            pull <= 1'b0; st <= ST_WADR;
                        end
                    end
                    ST_ACKW: begin
                        bcnt <= '0; pull <= 1'b0; st <= ST_WDATA;
                    end
                    ST_RDATA: begin
                        if (bdone) begin
                            bdone <= 1'b0; pull <= 1'b0; st <= ST_RACK; mack <= 1'b0;
                        end else begin
                            tx   <= {tx[DATA_W-2:0], 1'b0};
                            pull <= !tx[DATA_W-2];
                        end
                    end
                    ST_RACK: begin
                        bcnt <= '0;
                        if (mack) begin
                            tx <= rd_data_i; pull <= !rd_data_i[DATA_W-1]; st <= ST_RDATA;
                        end else begin
                            pull <= 1'b0; hold <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/twm_slave_chk.sv
// Protocol checker for twm_slave, bound to every instance of it.
// Assumes access to the synchronized samples and the sequencer state.
module twm_slave_chk (
    input logic            clk,
    input logic            rst_n,
    input logic            scl_s,
    input logic            start_ev,
    input logic            stop_ev,
    input logic            pull,
    input logic            hold,
    input logic            wr_valid,
    input twm_pkg::state_t st
);
    import twm_pkg::*;

    // R10
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pull) |-> !scl_s);

    // R3
    wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R3
    wr_pulse_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (st == ST_ACKW && pull));

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (st == ST_IDLE && !pull));

    // R9
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (st == ST_DEVADR && !pull));

    // R7
    nack_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !start_ev) |=> !pull);

endmodule

bind twm_slave twm_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_ev(start_ev),
    .stop_ev(stop_ev), .pull(pull), .hold(hold), .wr_valid(wr_valid_o), .st(st)
);

// File: tb/tb_twm_slave.sv
`timescale 1ns/1ps
module tb_twm_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, msda = 1'b1;
    logic pull, wr_valid;
    logic [1:0] strap = 2'b10;
    logic [8:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;
    wire  sda = msda & ~pull;

    int checks = 0, errors = 0, viol = 0, wr_cnt = 0;
    logic [8:0] wlog_a [16];
    logic [7:0] wlog_d [16];
    logic pull_q = 1'b0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [7:0] pat(input logic [8:0] a);
        return ((a[7:0] * 8'd37) + 8'd11) ^ (a[8] ? 8'hA5 : 8'h00);
    endfunction
    assign rd_data = pat(rd_addr);

    twm_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_pull_o(pull),
        .strap_i(strap), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    // Logs write handoffs and pull changes seen with the clock line high.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin
                if (wr_cnt < 16) begin
                    wlog_a[wr_cnt] = wr_addr;
                    wlog_d[wr_cnt] = wr_data;
                end
                wr_cnt++;
            end
            if (pull != pull_q && scl) viol++;
        end
        pull_q = pull;
    end

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        scl = 1'b0; hold(10); msda = 1'b1; hold(10);
        scl = 1'b1; hold(20); msda = 1'b0; hold(20); scl = 1'b0; hold(10);
    endtask

    task automatic bus_stop();
        scl = 1'b0; hold(10); msda = 1'b0; hold(10);
        scl = 1'b1; hold(20); msda = 1'b1; hold(20);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        scl = 1'b0; hold(10); msda = b; hold(10);
        scl = 1'b1; hold(10); seen = sda; hold(10);
        scl = 1'b0; hold(2);
    endtask

    // Sends a byte MSB first and returns the line level on the ninth clock.
    task automatic send_byte(input logic [7:0] v, output logic ackbit);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        clk_bit(1'b1, ackbit);
    endtask

    // Reads a byte and answers with the given ninth-clock level.
    task automatic recv_byte(input logic nack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(nack, s);
    endtask

    task automatic t_reset();
        chk(pull == 1'b0, "R8 reset release", pull, 0);
        chk(wr_valid == 1'b0, "R8 reset no write", wr_valid, 0);
    endtask

    task automatic t_no_start();
        logic a;
        send_byte(8'hA8, a);
        chk(a == 1'b1, "R1 no ack without start", a, 1);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start(); send_byte(8'hA0, a);
        chk(a == 1'b1, "R2 strap mismatch nack", a, 1);
        send_byte(8'h00, a);
        chk(a == 1'b1, "R2 silent after mismatch", a, 1);
        bus_stop();
        bus_start(); send_byte(8'hB8, a);
        chk(a == 1'b1, "R2 wrong device type nack", a, 1);
        bus_stop();
    endtask

    task automatic t_write();
        logic a;
        int base = wr_cnt;
        bus_start(); send_byte(8'hAA, a);
        chk(a == 1'b0, "R2 address match ack", a, 0);
        send_byte(8'hFE, a);
        chk(a == 1'b0, "R3 word address ack", a, 0);
        send_byte(8'h11, a); chk(a == 1'b0, "R3 data ack 0", a, 0);
        send_byte(8'h22, a); chk(a == 1'b0, "R3 data ack 1", a, 0);
        send_byte(8'h33, a); chk(a == 1'b0, "R3 data ack 2", a, 0);
        bus_stop();
        chk(wr_cnt == base + 3, "R3 write pulse count", wr_cnt - base, 3);
        chk(wlog_a[base] == 9'h1FE && wlog_d[base] == 8'h11, "R3 first handoff", int'(wlog_a[base]), 'h1FE);
        chk(wlog_a[base+1] == 9'h1FF && wlog_d[base+1] == 8'h22, "R4 increment", int'(wlog_a[base+1]), 'h1FF);
        chk(wlog_a[base+2] == 9'h000 && wlog_d[base+2] == 8'h33, "R4 wrap to 0", int'(wlog_a[base+2]), 0);
    endtask

    task automatic t_abort();
        logic a, s;
        int base = wr_cnt;
        bus_start(); send_byte(8'hA8, a); send_byte(8'h10, a);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
        bus_start();
        chk(wr_cnt == base, "R9 partial byte dropped", wr_cnt - base, 0);
        send_byte(8'hA8, a);
        chk(a == 1'b0, "R9 address restart ack", a, 0);
        bus_stop();
    endtask

    task automatic t_random_read();
        logic a;
        logic [7:0] v;
        bus_start(); send_byte(8'hA8, a); send_byte(8'h40, a);
        bus_start(); send_byte(8'hAB, a);
        chk(a == 1'b0, "R5 read address ack", a, 0);
        recv_byte(1'b1, v);
        chk(v == pat(9'h140), "R5 random read data", v, pat(9'h140));
        bus_stop();
    endtask

    task automatic t_seq_read();
        logic a;
        logic [7:0] v;
        bus_start(); send_byte(8'hAA, a); send_byte(8'hFE, a);
        bus_start(); send_byte(8'hAB, a);
        recv_byte(1'b0, v); chk(v == pat(9'h1FE), "R6 seq byte 0", v, pat(9'h1FE));
        recv_byte(1'b0, v); chk(v == pat(9'h1FF), "R6 seq byte 1", v, pat(9'h1FF));
        recv_byte(1'b1, v); chk(v == pat(9'h000), "R4 read wrap", v, pat(9'h000));
        recv_byte(1'b1, v);
        chk(v == 8'hFF, "R7 silent after nack", v, 'hFF);
        bus_stop();
        chk(pull == 1'b0, "R8 released after stop", pull, 0);
        bus_start(); send_byte(8'hA8, a);
        chk(a == 1'b0, "R8 served after stop", a, 0);
        bus_stop();
    endtask

    initial begin
        hold(5);
        t_reset();
        rst_n = 1'b1;
        hold(10);
        t_reset();
        t_no_start();
        t_mismatch();
        t_write();
        t_abort();
        t_random_read();
        t_seq_read();
        chk(viol == 0, "R10 pull changes only with clock low", viol, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule